// File: doc/BRIEF.md
# Dual-Port Byte-Lane RAM with Address Hold

This block is a synchronous on-chip memory with two independent ports, A and B, that run on a single shared clock. Each port registers its address, write data, write enable and per-byte write enables on a clock edge. On the next edge the port performs the access and registers its read word. The data word is split into 8-bit lanes, and each lane has its own write-enable bit. A lane whose bit is low keeps its stored byte and returns that byte on the read output.

Each port has an active-high stall input. While stall is high, the port's address register keeps its current value and ignores the presented address. Reads and writes issued during a stall therefore go to the held location. A parameter sets what an enabled lane shows on the read output in the cycle it is written: either the byte being written or the byte that was stored before the write. If both ports write the same word in the same cycle, port A's byte is stored in every lane that both ports enable.

Top module: `bmram_dp`

## Requirements
- R1: During a write, a lane whose byte-enable bit is low is not changed in memory. The port's read output shows the old stored byte in that lane. Byte-enable bit i controls data bits [8i+7:8i].
- R2: During a write, an enabled lane's read output depends on the parameter `RDW_MODE`. With `RDW_SHOW_NEW` it shows the byte being written. With `RDW_SHOW_OLD` it shows the byte stored before the write.
- R3: While a port's stall input is high, its address register keeps its previous value and the presented address is ignored. Reads issued during the stall return data from the held address.
- R4: A write issued while the port is stalled updates the held address. The presented address is left unchanged.
- R5: A port's stall input has no effect on the address that the other port uses.
- R6: Inputs sampled at clock edge k produce their read word on the port's read output after edge k+1. Before edge k+1 the output still shows its previous value.
- R7: When both ports write the same address in the same cycle, a lane enabled on both ports stores port A's byte. A lane enabled on only one port stores that port's byte.
- R8: When a port's write enable is low, its byte enables are ignored. Memory is not changed, and the full stored word is returned.
- R9: While reset is asserted, both read outputs are zero and no write is performed.
- R10: A port that reads an address in the same cycle as the other port writes that address returns the contents stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low reset of the port registers |
| a_stall | input | 1 | Port A address hold, active high |
| a_addr | input | ADDR_W | Port A address |
| a_we | input | 1 | Port A write enable |
| a_be | input | DATA_W/8 | Port A per-lane write enables |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_stall | input | 1 | Port B address hold, active high |
| b_addr | input | ADDR_W | Port B address |
| b_we | input | 1 | Port B write enable |
| b_be | input | DATA_W/8 | Port B per-lane write enables |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
Every operation presented before edge k shows its read word after edge k+1. The bench drives inputs on the falling edge, lets two rising edges pass, and samples on the following falling edge. For the second of those cycles it holds the address and stall and drops the write enable. One check samples after only the first edge to confirm the output has not yet moved. Two instances with opposite read-during-write settings receive identical stimulus, so the written-lane and masked-lane results are compared for both settings in the same cycle.

// File: rtl/bmram_pkg.sv
package bmram_pkg;
   localparam int unsigned LANE_W = 8;

   typedef enum logic {
      RDW_SHOW_NEW = 1'b0,
      RDW_SHOW_OLD = 1'b1
   } rdw_mode_e;
endpackage

// File: rtl/bmram_addr_hold.sv
module bmram_addr_hold #(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] addr_q
);
   logic [ADDR_W-1:0] addr_nxt;

   // feedback multiplexer selected by the stall input
   assign addr_nxt = stall ? addr_q : addr_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= addr_nxt;
   end

   p_stall_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> addr_q == $past(addr_q));

   p_addr_load_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> addr_q == $past(addr_in));
endmodule

// File: rtl/bmram_port_in.sv
module bmram_port_in #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LANES  = 4,
   localparam int unsigned DW    = LANES * bmram_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [LANES-1:0]  be,
   input  logic [DW-1:0]     wdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic [LANES-1:0]  lane_wr,
   output logic [DW-1:0]     wdata_q
);
   logic             we_q;
   logic [LANES-1:0] be_q;

   bmram_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .stall   (stall),
      .addr_in (addr),
      .addr_q  (addr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
      end else begin
         we_q    <= we;
         be_q    <= be;
         wdata_q <= wdata;
      end
   end

   // byte enables only matter with the write enable set
   assign lane_wr = we_q ? be_q : '0;

   p_no_wr_in_reset_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> lane_wr == '0);

   p_idle_masks_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> lane_wr == '0);
endmodule

// File: rtl/bmram_lane.sv
module bmram_lane #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DEPTH    = 256,
   parameter bit          SHOW_NEW = 1'b1,
   localparam int unsigned LW      = bmram_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_wr,
   input  logic [LW-1:0]     a_wd,
   output logic [LW-1:0]     a_rd,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_wr,
   input  logic [LW-1:0]     b_wd,
   output logic [LW-1:0]     b_rd
);
   logic [LW-1:0] mem [DEPTH];
   logic [LW-1:0] a_old, b_old, a_nxt, b_nxt;

   assign a_old = mem[a_addr];
   assign b_old = mem[b_addr];

   // port B first, so port A's later assignment wins a collision
   always_ff @(posedge clk) begin
      if (b_wr) mem[b_addr] <= b_wd;
      if (a_wr) mem[a_addr] <= a_wd;
   end

   if (SHOW_NEW) begin : g_show_new
      assign a_nxt = a_wr ? a_wd : a_old;
      assign b_nxt = b_wr ? b_wd : b_old;

      p_rdw_new_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         a_wr |=> a_rd == $past(a_wd));
   end else begin : g_show_old
      assign a_nxt = a_old;
      assign b_nxt = b_old;

      p_rdw_old_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         b_wr |=> b_rd == $past(b_old));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rd <= '0;
         b_rd <= '0;
      end else begin
         a_rd <= a_nxt;
         b_rd <= b_nxt;
      end
   end

   p_a_wins_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (a_wr && b_wr && a_addr == b_addr) |=> mem[$past(a_addr)] == $past(a_wd));

   p_masked_keep_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!a_wr && !b_wr) |=> mem[$past(a_addr)] == $past(a_old));
endmodule

// File: rtl/bmram_dp.sv
module bmram_dp #(
   parameter int unsigned           DATA_W   = 32,
   parameter int unsigned           DEPTH    = 256,
   parameter bmram_pkg::rdw_mode_e  RDW_MODE = bmram_pkg::RDW_SHOW_NEW,
   localparam int unsigned          ADDR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned          LANES    = DATA_W / bmram_pkg::LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_stall,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              a_we,
   input  logic [LANES-1:0]  a_be,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_stall,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic              b_we,
   input  logic [LANES-1:0]  b_be,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   import bmram_pkg::*;

   localparam int unsigned NPORT    = 2;
   localparam bit          SHOW_NEW = (RDW_MODE == RDW_SHOW_NEW);

   if (DATA_W == 0 || (DATA_W % LANE_W) != 0) begin : g_bad_width
      $error("bmram_dp: DATA_W must be a nonzero multiple of the lane width");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("bmram_dp: DEPTH must be at least 2");
   end

   logic              stall_v [NPORT];
   logic [ADDR_W-1:0] addr_v  [NPORT];
   logic              we_v    [NPORT];
   logic [LANES-1:0]  be_v    [NPORT];
   logic [DATA_W-1:0] wd_v    [NPORT];
   logic [ADDR_W-1:0] addr_q  [NPORT];
   logic [LANES-1:0]  wr_q    [NPORT];
   logic [DATA_W-1:0] wd_q    [NPORT];

   assign stall_v[0] = a_stall;  assign stall_v[1] = b_stall;
   assign addr_v[0]  = a_addr;   assign addr_v[1]  = b_addr;
   assign we_v[0]    = a_we;     assign we_v[1]    = b_we;
   assign be_v[0]    = a_be;     assign be_v[1]    = b_be;
   assign wd_v[0]    = a_wdata;  assign wd_v[1]    = b_wdata;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      bmram_port_in #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in (
         .clk     (clk),
         .rst_n   (rst_n),
         .stall   (stall_v[p]),
         .addr    (addr_v[p]),
         .we      (we_v[p]),
         .be      (be_v[p]),
         .wdata   (wd_v[p]),
         .addr_q  (addr_q[p]),
         .lane_wr (wr_q[p]),
         .wdata_q (wd_q[p])
      );
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      bmram_lane #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .SHOW_NEW(SHOW_NEW)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .a_addr (addr_q[0]),
         .a_wr   (wr_q[0][l]),
         .a_wd   (wd_q[0][l*LANE_W +: LANE_W]),
         .a_rd   (a_rdata[l*LANE_W +: LANE_W]),
         .b_addr (addr_q[1]),
         .b_wr   (wr_q[1][l]),
         .b_wd   (wd_q[1][l*LANE_W +: LANE_W]),
         .b_rd   (b_rdata[l*LANE_W +: LANE_W])
      );
   end

   p_reset_zero_r9 : assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (a_rdata == '0 && b_rdata == '0)));

   p_stall_indep_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (a_stall && !b_stall) |=> addr_q[1] == $past(b_addr));
endmodule

// File: tb/bmram_dp_bench.sv
`timescale 1ns/1ps
module bmram_dp_bench;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 8;
   localparam int unsigned NB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic a_stall, a_we, b_stall, b_we;
   logic [AW-1:0] a_addr, b_addr;
   logic [NB-1:0] a_be, b_be;
   logic [DW-1:0] a_wdata, b_wdata;
   logic [DW-1:0] a_rdata, b_rdata, oa_rdata, ob_rdata;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   bmram_dp #(.DATA_W(DW), .DEPTH(256), .RDW_MODE(bmram_pkg::RDW_SHOW_NEW)) u_bmram_dp (
      .clk(clk), .rst_n(rst_n),
      .a_stall(a_stall), .a_addr(a_addr), .a_we(a_we), .a_be(a_be),
      .a_wdata(a_wdata), .a_rdata(a_rdata),
      .b_stall(b_stall), .b_addr(b_addr), .b_we(b_we), .b_be(b_be),
      .b_wdata(b_wdata), .b_rdata(b_rdata));

   bmram_dp #(.DATA_W(DW), .DEPTH(256), .RDW_MODE(bmram_pkg::RDW_SHOW_OLD)) u_bmram_dp_old (
      .clk(clk), .rst_n(rst_n),
      .a_stall(a_stall), .a_addr(a_addr), .a_we(a_we), .a_be(a_be),
      .a_wdata(a_wdata), .a_rdata(oa_rdata),
      .b_stall(b_stall), .b_addr(b_addr), .b_we(b_we), .b_be(b_be),
      .b_wdata(b_wdata), .b_rdata(ob_rdata));

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   // present an operation, then one read cycle on the same addresses;
   // returns at the falling edge where the operation's read words are due
   task automatic run(input logic ast, input logic awe, input logic [NB-1:0] abe,
                      input logic [AW-1:0] aad, input logic [DW-1:0] awd,
                      input logic bst, input logic bwe, input logic [NB-1:0] bbe,
                      input logic [AW-1:0] bad, input logic [DW-1:0] bwd);
      a_stall = ast; a_we = awe; a_be = abe; a_addr = aad; a_wdata = awd;
      b_stall = bst; b_we = bwe; b_be = bbe; b_addr = bad; b_wdata = bwd;
      step();
      a_we = 1'b0; b_we = 1'b0;
      step();
   endtask

   task automatic wr_a(input logic [AW-1:0] ad, input logic [DW-1:0] wd);
      run(1'b0, 1'b1, 4'hF, ad, wd, 1'b0, 1'b0, 4'h0, 8'd0, 32'd0);
   endtask

   task automatic rd_a(input logic [AW-1:0] ad);
      run(1'b0, 1'b0, 4'h0, ad, 32'd0, 1'b0, 1'b0, 4'h0, 8'd0, 32'd0);
   endtask

   task automatic t_reset();
      chk("R9 reset a_rdata", a_rdata, 32'd0);
      chk("R9 reset b_rdata", b_rdata, 32'd0);
      chk("R9 reset old-mode a_rdata", oa_rdata, 32'd0);
   endtask

   task automatic t_latency();
      wr_a(8'd9, 32'h9999_9999);
      wr_a(8'd20, 32'hC0C0_C0C0);
      wr_a(8'd30, 32'h1234_5678);
      a_stall = 1'b0; a_we = 1'b0; a_addr = 8'd30;
      b_stall = 1'b0; b_we = 1'b0; b_addr = 8'd0;
      step();
      a_we = 1'b1; a_be = 4'hF; a_addr = 8'd5; a_wdata = 32'h1122_3344;
      step();
      // one edge has passed: the output still shows the address-30 read
      chk("R6 output not yet updated", a_rdata, 32'h1234_5678);
      a_we = 1'b0;
      step();
      chk("R6 write word after second edge", a_rdata, 32'h1122_3344);
      rd_a(8'd5);
      chk("R6 readback new-mode", a_rdata, 32'h1122_3344);
      chk("R6 readback old-mode", oa_rdata, 32'h1122_3344);
   endtask

   task automatic t_mask();
      run(1'b0, 1'b1, 4'b0101, 8'd5, 32'hAABB_CCDD, 1'b0, 1'b0, 4'h0, 8'd0, 32'd0);
      chk("R2 new-mode enabled lanes, R1 masked lanes", a_rdata, 32'h11BB_33DD);
      chk("R2 old-mode shows prior word", oa_rdata, 32'h1122_3344);
      rd_a(8'd5);
      chk("R1 masked lanes kept in memory", a_rdata, 32'h11BB_33DD);
      chk("R1 masked lanes kept, old-mode copy", oa_rdata, 32'h11BB_33DD);
   endtask

   task automatic t_idle_be();
      run(1'b0, 1'b0, 4'hF, 8'd5, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'hF, 8'd5, 32'hFFFF_FFFF);
      chk("R8 be ignored, full word returned", a_rdata, 32'h11BB_33DD);
      chk("R8 be ignored on port B", b_rdata, 32'h11BB_33DD);
      rd_a(8'd5);
      chk("R8 memory unchanged", a_rdata, 32'h11BB_33DD);
   endtask

   task automatic t_stall();
      rd_a(8'd5);
      run(1'b1, 1'b0, 4'h0, 8'd9, 32'd0, 1'b0, 1'b0, 4'h0, 8'd0, 32'd0);
      chk("R3 stalled read returns held address", a_rdata, 32'h11BB_33DD);
      run(1'b1, 1'b1, 4'hF, 8'd9, 32'h5566_7788, 1'b0, 1'b0, 4'h0, 8'd0, 32'd0);
      chk("R4 stalled write lands on held address", a_rdata, 32'h5566_7788);
      rd_a(8'd5);
      chk("R4 held address updated", a_rdata, 32'h5566_7788);
      rd_a(8'd9);
      chk("R4 presented address untouched", a_rdata, 32'h9999_9999);
   endtask

   task automatic t_indep();
      rd_a(8'd5);
      run(1'b1, 1'b0, 4'h0, 8'd30, 32'd0, 1'b0, 1'b0, 4'h0, 8'd9, 32'd0);
      chk("R5 B follows its address while A stalled", b_rdata, 32'h9999_9999);
      chk("R3 A still on held address", a_rdata, 32'h5566_7788);
      run(1'b0, 1'b0, 4'h0, 8'd30, 32'd0, 1'b1, 1'b0, 4'h0, 8'd20, 32'd0);
      chk("R5 A follows its address while B stalled", a_rdata, 32'h1234_5678);
      chk("R5 B held on address 9", b_rdata, 32'h9999_9999);
   endtask

   task automatic t_collide();
      run(1'b0, 1'b1, 4'b0011, 8'd20, 32'hA1A2_A3A4, 1'b0, 1'b1, 4'b0110, 8'd20, 32'hB1B2_B3B4);
      rd_a(8'd20);
      chk("R7 shared lane takes port A byte", a_rdata, 32'hC0B2_A3A4);
   endtask

   task automatic t_cross();
      run(1'b0, 1'b1, 4'hF, 8'd30, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'h0, 8'd30, 32'd0);
      chk("R10 B reads contents before A's write", b_rdata, 32'h1234_5678);
      chk("R10 old-mode B reads prior contents", ob_rdata, 32'h1234_5678);
      chk("R2 new-mode A shows written word", a_rdata, 32'hDEAD_BEEF);
      run(1'b0, 1'b0, 4'h0, 8'd30, 32'd0, 1'b0, 1'b0, 4'h0, 8'd30, 32'd0);
      chk("R10 B sees write afterwards", b_rdata, 32'hDEAD_BEEF);
   endtask

   initial begin
      a_stall = 1'b0; a_we = 1'b0; a_be = '0; a_addr = '0; a_wdata = '0;
      b_stall = 1'b0; b_we = 1'b0; b_be = '0; b_addr = '0; b_wdata = '0;
      // a write request held during reset must not reach memory
      a_we = 1'b1; a_be = 4'hF;
      repeat (4) step();
      t_reset();
      a_we = 1'b0; a_be = '0;
      step();
      rst_n = 1'b1;
      step();
      t_latency();
      t_mask();
      t_idle_be();
      t_stall();
      t_indep();
      t_collide();
      t_cross();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule